// File: doc/BRIEF.md
# Cascaded Two-Level Search Winner Arbiter

This block picks one global winner after each search command issued to a cascade of search engines (fifteen by default). Each engine presents a hit flag and the address it matched. Engines are split into groups of at most four, with engine `i` in group `i / GSZ`. With the defaults this gives four groups holding 4, 4, 4 and 3 engines. The hit flags and addresses are read in one fixed cycle after the command.

Resolution takes two registered stages. In the first stage, each group picks its own candidate. In the second stage, the groups compete and the candidate of the winning group becomes the global winner. The block then presents a global hit flag, the winning engine index, the matched address, and a one-hot drive enable. The drive enable tells exactly one engine to drive the shared result bus in that cycle.

When no engine hits, the final engine of the cascade acts as the last device. It reports the miss and takes the bus. A new command may be issued on every cycle. Overlapping searches resolve independently and in issue order.

Top module: `srch_cascade_arb`

## Requirements
- R1: While reset is held, and in the first cycle after reset releases, `res_valid` is 0 and `drv_en` is all zeros.
- R2: A command sampled on edge C has its engine results sampled on edge C+4, and its outcome is presented on the outputs during the cycle after edge C+5 (six cycles after the command). `res_valid` is high only in that cycle.
- R3: `eng_hit` and `eng_addr` have no effect in any cycle that is not the fourth cycle after a command. Such values produce no `res_valid` and leave the other searches' results unchanged.
- R4: Within a group, the hitting engine with the lowest index wins.
- R5: Across groups, the lowest-numbered group that holds a hit wins. Engine `i` belongs to group `i / GSZ`, and the last group holds only the remaining engines.
- R6: On a hit, `win_idx` is the winning engine's global index and `win_addr` equals bits `[i*AW +: AW]` of `eng_addr` for that engine `i`.
- R7: On a miss, `glb_hit` is 0, `win_idx` is NENG-1, `win_addr` is 0, and `drv_en` has only bit NENG-1 set.
- R8: While `res_valid` is high, `drv_en` has exactly one bit set, and on a hit that bit is `win_idx`. While `res_valid` is low, `drv_en` is zero.
- R9: Commands on consecutive cycles each produce their own result on consecutive cycles, in issue order, with no interference between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Search command issued this cycle |
| eng_hit | input | NENG | Per-engine hit flag, read in the fourth cycle after a command |
| eng_addr | input | NENG*AW | Per-engine matched address, engine i at bits [i*AW +: AW] |
| res_valid | output | 1 | Result of a search is presented this cycle |
| glb_hit | output | 1 | Some engine hit |
| win_idx | output | IW | Index of the winning engine (NENG-1 on a miss) |
| win_addr | output | AW | Address matched by the winner (0 on a miss) |
| drv_en | output | NENG | One-hot result-bus drive enable |

## Verification
The hardest situation to reach is a dense pipeline. In it, several searches are in flight at once, while hit inputs that do not belong to any search carry conflicting data in the gaps between due cycles. A misaligned sample stage would then pick up the wrong pattern or return a stray result. The stimulus reaches this state by issuing bursts of commands on every cycle and at wider spacing. Every non-due cycle is flooded with all-ones hit flags and junk addresses, and each burst mixes hits in every group with misses and hits on the last engine.

// File: rtl/srch_arb_pkg.sv
package srch_arb_pkg;

    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/srch_grp_pick.sv
module srch_grp_pick #(
    parameter int GSZ = 4,
    parameter int AW  = 16,
    parameter int LW  = 2
) (
    input  logic [GSZ-1:0]    hit,
    input  logic [GSZ*AW-1:0] addr,
    output logic              any,
    output logic [LW-1:0]     idx,
    output logic [AW-1:0]     sel_addr
);
    always_comb begin
        any      = |hit;
        idx      = '0;
        sel_addr = '0;
        for (int i = GSZ - 1; i >= 0; i--) begin
            if (hit[i]) begin
                idx      = LW'(i);
                sel_addr = addr[i*AW +: AW];
            end
        end
    end
endmodule

// File: rtl/srch_top_pick.sv
module srch_top_pick #(
    parameter int NGRP = 4,
    parameter int GSZ  = 4,
    parameter int AW   = 16,
    parameter int LW   = 2,
    parameter int IW   = 4
) (
    input  logic [NGRP-1:0]    g_any,
    input  logic [NGRP*LW-1:0] g_idx,
    input  logic [NGRP*AW-1:0] g_addr,
    output logic               hit,
    output logic [IW-1:0]      idx,
    output logic [AW-1:0]      sel_addr
);
    always_comb begin
        hit      = |g_any;
        idx      = '0;
        sel_addr = '0;
        for (int g = NGRP - 1; g >= 0; g--) begin
            if (g_any[g]) begin
                idx      = IW'(g * GSZ) + IW'(g_idx[g*LW +: LW]);
                sel_addr = g_addr[g*AW +: AW];
            end
        end
    end
endmodule

// File: rtl/srch_cascade_arb.sv
module srch_cascade_arb
    import srch_arb_pkg::*;
#(
    parameter int NENG    = 15,
    parameter int GSZ     = 4,
    parameter int AW      = 16,
    parameter int RES_LAT = 4,
    parameter int IW      = idx_w(NENG)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    input  logic [NENG-1:0]    eng_hit,
    input  logic [NENG*AW-1:0] eng_addr,
    output logic               res_valid,
    output logic               glb_hit,
    output logic [IW-1:0]      win_idx,
    output logic [AW-1:0]      win_addr,
    output logic [NENG-1:0]    drv_en
);
    localparam int NGRP = ceil_div(NENG, GSZ);
    localparam int NPAD = NGRP * GSZ;
    localparam int LW   = idx_w(GSZ);
    localparam logic [NENG-1:0] LAST_ONE = {1'b1, {(NENG-1){1'b0}}};
    localparam logic [NENG-1:0] ONE      = NENG'(1);

    // Command tracking: high bit marks the cycle results are due
    logic [RES_LAT-1:0] due_q;
    logic               due;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) due_q <= '0;
        else        due_q <= {due_q[RES_LAT-2:0], cmd_valid};
    end
    assign due = due_q[RES_LAT-1];

    // Pad the cascade to a whole number of groups with non-hitting slots
    logic [NPAD-1:0]    hit_pad;
    logic [NPAD*AW-1:0] addr_pad;
    assign hit_pad  = NPAD'(eng_hit);
    assign addr_pad = (NPAD*AW)'(eng_addr);

    // Stage 1: in-group selection
    logic [NGRP-1:0]    g_any;
    logic [NGRP*LW-1:0] g_idx;
    logic [NGRP*AW-1:0] g_addr;

    for (genvar g = 0; g < NGRP; g++) begin : gen_grp
        srch_grp_pick #(.GSZ(GSZ), .AW(AW), .LW(LW)) u_pick (
            .hit      (hit_pad[g*GSZ +: GSZ]),
            .addr     (addr_pad[g*GSZ*AW +: GSZ*AW]),
            .any      (g_any[g]),
            .idx      (g_idx[g*LW +: LW]),
            .sel_addr (g_addr[g*AW +: AW])
        );
    end

    logic               s1_vld;
    logic [NGRP-1:0]    s1_any;
    logic [NGRP*LW-1:0] s1_idx;
    logic [NGRP*AW-1:0] s1_addr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_vld  <= 1'b0;
            s1_any  <= '0;
            s1_idx  <= '0;
            s1_addr <= '0;
        end else begin
            s1_vld  <= due;
            s1_any  <= due ? g_any  : '0;
            s1_idx  <= due ? g_idx  : '0;
            s1_addr <= due ? g_addr : '0;
        end
    end

    // Stage 2: cross-group selection
    logic          pk_hit;
    logic [IW-1:0] pk_idx;
    logic [AW-1:0] pk_addr;

    srch_top_pick #(.NGRP(NGRP), .GSZ(GSZ), .AW(AW), .LW(LW), .IW(IW)) u_top (
        .g_any    (s1_any),
        .g_idx    (s1_idx),
        .g_addr   (s1_addr),
        .hit      (pk_hit),
        .idx      (pk_idx),
        .sel_addr (pk_addr)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            glb_hit   <= 1'b0;
            win_idx   <= '0;
            win_addr  <= '0;
            drv_en    <= '0;
        end else if (!s1_vld) begin
            res_valid <= 1'b0;
            glb_hit   <= 1'b0;
            win_idx   <= '0;
            win_addr  <= '0;
            drv_en    <= '0;
        end else if (pk_hit) begin
            res_valid <= 1'b1;
            glb_hit   <= 1'b1;
            win_idx   <= pk_idx;
            win_addr  <= pk_addr;
            drv_en    <= ONE << pk_idx;
        end else begin
            res_valid <= 1'b1;
            glb_hit   <= 1'b0;
            win_idx   <= IW'(NENG - 1);
            win_addr  <= '0;
            drv_en    <= LAST_ONE;
        end
    end
endmodule

// File: rtl/srch_cascade_arb_chk.sv
module srch_cascade_arb_chk #(
    parameter int NENG = 15,
    parameter int AW   = 16,
    parameter int IW   = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cmd_valid,
    input logic            res_valid,
    input logic            glb_hit,
    input logic [IW-1:0]   win_idx,
    input logic [AW-1:0]   win_addr,
    input logic [NENG-1:0] drv_en
);
    logic [5:0] cmd_hist;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cmd_hist <= '0;
        else        cmd_hist <= {cmd_hist[4:0], cmd_valid};
    end

    assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid == cmd_hist[5]);

    assert_one_driver_R8: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> ($countones(drv_en) == 1));

    assert_quiet_bus_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> (drv_en == '0));

    assert_winner_drives_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && glb_hit) |-> (drv_en == (NENG'(1) << win_idx)));

    assert_miss_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !glb_hit) |->
            (drv_en[NENG-1] && win_idx == IW'(NENG - 1) && win_addr == '0));
endmodule

bind srch_cascade_arb srch_cascade_arb_chk #(.NENG(NENG), .AW(AW), .IW(IW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .res_valid (res_valid),
    .glb_hit   (glb_hit),
    .win_idx   (win_idx),
    .win_addr  (win_addr),
    .drv_en    (drv_en)
);

// File: tb/srch_cascade_arb_test.sv
`timescale 1ns/1ps
module srch_cascade_arb_test;
    localparam int NENG = 15;
    localparam int AW   = 16;
    localparam int IW   = 4;

    logic               clk = 1'b0;
    logic               rst_n;
    logic               cmd_valid;
    logic [NENG-1:0]    eng_hit;
    logic [NENG*AW-1:0] eng_addr;
    logic               res_valid;
    logic               glb_hit;
    logic [IW-1:0]      win_idx;
    logic [AW-1:0]      win_addr;
    logic [NENG-1:0]    drv_en;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    logic [NENG-1:0] pat [0:15];

    always #2 clk = ~clk;

    srch_cascade_arb uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid),
        .eng_hit(eng_hit), .eng_addr(eng_addr),
        .res_valid(res_valid), .glb_hit(glb_hit), .win_idx(win_idx),
        .win_addr(win_addr), .drv_en(drv_en)
    );

    function automatic logic [AW-1:0] addr_of(input int k, input int e);
        return {k[7:0], e[7:0]} ^ 16'h5A00;
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // n searches, one every sp cycles; noise floods non-due cycles
    task automatic run_burst(input int n, input int sp, input bit noise, input string req);
        int total = n * sp + 8;
        for (int t = 0; t < total; t++) begin
            @(negedge clk);
            if (t >= 6 && (t - 6) % sp == 0 && (t - 6) / sp < n) begin
                int k = (t - 6) / sp;
                int w = -1;
                for (int e = NENG - 1; e >= 0; e--) if (pat[k][e]) w = e;
                check(req, "res_valid", 32'(res_valid), 32'd1);
                if (w < 0) begin
                    check("R7", "glb_hit miss", 32'(glb_hit), 32'd0);
                    check("R7", "win_idx miss", 32'(win_idx), 32'(NENG - 1));
                    check("R7", "win_addr miss", 32'(win_addr), 32'd0);
                    check("R7", "drv_en miss", 32'(drv_en), 32'(1 << (NENG - 1)));
                end else begin
                    check(req, "glb_hit", 32'(glb_hit), 32'd1);
                    check(req, "win_idx", 32'(win_idx), 32'(w));
                    check("R6", "win_addr", 32'(win_addr), 32'(addr_of(k, w)));
                    check("R8", "drv_en", 32'(drv_en), 32'(1 << w));
                end
            end else begin
                check("R3", "idle res_valid", 32'(res_valid), 32'd0);
                check("R8", "idle drv_en", 32'(drv_en), 32'd0);
            end
            cmd_valid = (t % sp == 0) && (t / sp < n);
            if (t >= 4 && (t - 4) % sp == 0 && (t - 4) / sp < n) begin
                int k = (t - 4) / sp;
                eng_hit = pat[k];
                for (int e = 0; e < NENG; e++) eng_addr[e*AW +: AW] = addr_of(k, e);
            end else begin
                eng_hit  = noise ? '1 : '0;
                eng_addr = noise ? {NENG{16'hBEEF}} : '0;
            end
        end
        cmd_valid = 1'b0;
        eng_hit   = '0;
        eng_addr  = '0;
    endtask

    task automatic test_reset();
        rst_n = 1'b0; cmd_valid = 1'b0; eng_hit = '0; eng_addr = '0;
        repeat (3) @(negedge clk);
        check("R1", "reset res_valid", 32'(res_valid), 32'd0);
        check("R1", "reset drv_en", 32'(drv_en), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "post-reset res_valid", 32'(res_valid), 32'd0);
        check("R1", "post-reset drv_en", 32'(drv_en), 32'd0);
    endtask

    task automatic test_in_group();   // R4
        pat[0] = 15'b000_0000_0000_1100;
        pat[1] = 15'b000_0000_1010_0000;
        pat[2] = 15'b000_1110_0000_0000;
        pat[3] = 15'b110_0000_0000_0000;
        pat[4] = 15'b100_0000_0000_0000;
        run_burst(5, 8, 1'b0, "R2 R4");
    endtask

    task automatic test_cross_group(); // R5
        pat[0] = 15'b111_1111_1111_1000;
        pat[1] = 15'b001_1000_0100_0000;
        pat[2] = 15'b100_0000_1000_0000;
        pat[3] = 15'b010_1000_0000_0000;
        pat[4] = 15'b001_0000_0000_0000;
        run_burst(5, 7, 1'b0, "R5");
    endtask

    task automatic test_miss();        // R7
        pat[0] = '0;
        pat[1] = 15'b100_0000_0000_0000;
        pat[2] = '0;
        run_burst(3, 7, 1'b0, "R7");
    endtask

    task automatic test_noise();       // R3
        pat[0] = 15'b000_0100_0000_0000;
        pat[1] = '0;
        pat[2] = 15'b000_0000_0000_0001;
        run_burst(3, 3, 1'b1, "R3");
        run_burst(0, 1, 1'b1, "R3");
    endtask

    task automatic test_back_to_back(); // R9
        for (int k = 0; k < 16; k++) pat[k] = NENG'(1) << (15 - k);
        pat[0] = '0;
        pat[5] = 15'b010_0010_0000_0000;
        pat[9] = '1;
        run_burst(16, 1, 1'b1, "R9");
    endtask

    initial begin
        test_reset();
        test_in_group();
        test_cross_group();
        test_miss();
        test_noise();
        test_back_to_back();
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end
endmodule